// File: doc/BRIEF.md
# Sync-Gated Sample Buffer with Fill Threshold

This block sits after a decimation filter in one converter channel. It takes filtered samples on a valid strobe, stores them in a small first-in first-out buffer, and tells software that data is ready. Storage can be held back until an external PWM synchronisation pulse has been seen. Each later pulse can also empty the buffer, so that every control period starts with a fresh set of samples.

Software sees a pop-on-read data port and a fill count. It also sees a separate data register that always holds the most recent accepted sample. Two sticky flags are provided, one for overflow and one for a seen synchronisation pulse, and each has its own way of being cleared. A ready-select input chooses what counts as "data ready" for the channel: either the buffer fill rising above a programmable threshold, or a fresh value in the data register. An enable input gates that readiness onto the interrupt line.

Top module: `sfifo_top`

## Requirements
- R1: After reset, fill is 0, fifoData and dataReg are 0, and syncFound, ovfErr, fifoReady, dataReady and irq are all 0.
- R2: A sample is accepted only when pathEn is 1. If waitSync is 0, every sample with pathEn high is accepted. If waitSync is 1, a sample is accepted only once a syncPulse has been seen while pathEn and waitSync were both high. A sample in the same cycle as that first pulse is not accepted. Dropping pathEn or waitSync disarms the gate.
- R3: The buffer holds DEPTH entries (16 by default). If a sample is accepted while the buffer is full and no pop happens in that cycle, the sample is dropped, the stored entries are kept, and ovfErr is set. Writing ovfClr=1 clears ovfErr. A new overflow in the same cycle wins over the clear.
- R4: Samples pop in arrival order. A pop requested with fifoRd in one cycle presents the entry on fifoData from the next clock edge, and fill drops by one.
- R5: A pop while the buffer is empty leaves fifoData at the last value popped and leaves fill at 0.
- R6: fifoReady is 1 exactly when fill is strictly greater than thresh (0..16). With thresh=16, fifoReady never asserts.
- R7: With readySel=1, dataReady follows fifoReady. With readySel=0, dataReady is set by each accepted sample (which also loads dataReg) and is cleared by a dataRd strobe.
- R8: irq equals irqEn AND dataReady.
- R9: While waitSync=1 and flushOnSync=1, each syncPulse empties the buffer; a sample accepted in that same cycle becomes its only entry. flushOnSync has no effect while waitSync=0.
- R10: syncFound is set by syncPulse. It is cleared by a syncManClr strobe. When syncAutoClr=1, it is also cleared once irqEn=1 and fifoReady=1. A pulse in the same cycle wins over either clear.
- R11: With wide32=1 the full 32-bit sample is stored. With wide32=0 the low 16 bits are stored sign-extended to 32 bits. The same formatting applies to dataReg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pathEn | input | 1 | Enables sample acceptance |
| waitSync | input | 1 | Hold storage until a sync pulse is seen |
| flushOnSync | input | 1 | Empty the buffer on each sync pulse (needs waitSync) |
| syncAutoClr | input | 1 | Clear syncFound automatically when the buffer interrupt condition holds |
| syncManClr | input | 1 | One-cycle strobe that clears syncFound |
| wide32 | input | 1 | 1: 32-bit samples, 0: sign-extended 16-bit samples |
| readySel | input | 1 | 1: threshold drives dataReady, 0: data register drives it |
| irqEn | input | 1 | Data-ready interrupt enable |
| thresh | input | 5 | Fill threshold, 0 to 16 |
| sampleValid | input | 1 | Sample strobe |
| sampleIn | input | 32 | Sample value |
| syncPulse | input | 1 | PWM synchronisation pulse |
| fifoRd | input | 1 | Pop strobe |
| dataRd | input | 1 | Data register read strobe |
| ovfClr | input | 1 | Write-1 clear of ovfErr |
| fill | output | 5 | Number of stored entries |
| fifoData | output | 32 | Last popped entry |
| dataReg | output | 32 | Most recent accepted sample |
| fifoReady | output | 1 | fill greater than thresh |
| dataReady | output | 1 | Channel data ready |
| syncFound | output | 1 | Sticky sync-seen flag |
| ovfErr | output | 1 | Sticky overflow flag |
| irq | output | 1 | Data-ready interrupt |

## Verification
The bench builds the block with its default parameters: a depth of 16, 32-bit storage and a 16-bit narrow format. With these values, filling the buffer to capacity and pushing one extra sample takes only seventeen strobes. That makes the dropped-sample path and the top of the threshold range (15 versus 16) easy to reach. The narrow format lets one pair of samples show both sign extension and zero upper bits. A scoreboard queue records which samples should survive the gating, flushes and overflow. Every pop is then compared against it, including pops from an empty buffer.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Strobes issued by the control each cycle to the storage datapath.
  typedef struct packed {
    logic push;     // write formatted sample into the buffer
    logic pop;      // move head entry to fifoData
    logic flush;    // empty the buffer (a same-cycle push lands at slot 0)
    logic loadReg;  // refresh the single data register
  } fifoStrobes_t;
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pathEn,
  input  logic             waitSync,
  input  logic             flushOnSync,
  input  logic             syncAutoClr,
  input  logic             syncManClr,
  input  logic             readySel,
  input  logic             irqEn,
  input  logic [CNT_W-1:0] thresh,
  input  logic             sampleValid,
  input  logic             syncPulse,
  input  logic             fifoRd,
  input  logic             dataRd,
  input  logic             ovfClr,
  input  logic [CNT_W-1:0] fill,
  output fifoStrobes_t     str,
  output logic             fifoReady,
  output logic             dataReady,
  output logic             syncFound,
  output logic             ovfErr,
  output logic             irq
);
  logic armed, regNew;
  logic gateOpen, take, isFull, isEmpty, flushNow, popOk, dropped, autoClr;

  always_comb begin
    gateOpen  = pathEn && (!waitSync || armed);
    take      = sampleValid && gateOpen;
    isFull    = (fill == CNT_W'(DEPTH));
    isEmpty   = (fill == '0);
    flushNow  = waitSync && flushOnSync && syncPulse;
    popOk     = fifoRd && !isEmpty && !flushNow;
    dropped   = take && isFull && !popOk && !flushNow;
    fifoReady = (fill > thresh);
    dataReady = readySel ? fifoReady : regNew;
    irq       = irqEn && dataReady;
    autoClr   = syncAutoClr && irqEn && fifoReady;
    str.push    = take && (flushNow || !isFull || popOk);
    str.pop     = popOk;
    str.flush   = flushNow;
    str.loadReg = take;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      regNew    <= 1'b0;
      syncFound <= 1'b0;
      ovfErr    <= 1'b0;
    end else begin
      if (!pathEn || !waitSync) armed <= 1'b0;
      else if (syncPulse)       armed <= 1'b1;

      if (take)        regNew <= 1'b1;
      else if (dataRd) regNew <= 1'b0;

      if (syncPulse)                  syncFound <= 1'b1;
      else if (syncManClr || autoClr) syncFound <= 1'b0;

      if (dropped)     ovfErr <= 1'b1;
      else if (ovfClr) ovfErr <= 1'b0;
    end
  end

  // Overflow of a full buffer with the gate open must raise the sticky flag.
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && pathEn && !waitSync && fill == CNT_W'(DEPTH) && !fifoRd) |=> ovfErr);

  assert_sync_sets_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> syncFound);

  assert_reg_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!readySel && dataRd && !sampleValid) |=> (readySel || !dataReady));
endmodule

// File: rtl/sfifo_datapath.sv
module sfifo_datapath
  import sfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DW     = 32,
  parameter int HALF_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     str,
  input  logic             wide32,
  input  logic [DW-1:0]    sampleIn,
  output logic [CNT_W-1:0] fill,
  output logic [DW-1:0]    fifoData,
  output logic [DW-1:0]    dataReg
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrSlot;
  logic [DW-1:0]    word;

  // Narrow format is only distinct when the storage is wider than it.
  generate
    if (DW > HALF_W) begin : gNarrow
      assign word = wide32 ? sampleIn
                           : {{(DW-HALF_W){sampleIn[HALF_W-1]}}, sampleIn[HALF_W-1:0]};
    end else begin : gFull
      logic unusedWide;
      assign unusedWide = wide32;
      assign word = sampleIn;
    end
  endgenerate

  assign wrSlot = str.flush ? '0 : wrPtr;

  always_ff @(posedge clk) begin
    if (str.push) mem[wrSlot] <= word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      fill     <= '0;
      fifoData <= '0;
      dataReg  <= '0;
    end else begin
      if (str.loadReg) dataReg <= word;
      if (str.flush) begin
        rdPtr <= '0;
        wrPtr <= str.push ? PTR_W'(1) : '0;
        fill  <= str.push ? CNT_W'(1) : '0;
      end else begin
        if (str.push) wrPtr <= wrPtr + 1'b1;
        if (str.pop) begin
          rdPtr    <= rdPtr + 1'b1;
          fifoData <= mem[rdPtr];
        end
        fill <= fill + CNT_W'(str.push) - CNT_W'(str.pop);
      end
    end
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNT_W'(DEPTH));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    str.flush |=> (fill <= CNT_W'(1)));
endmodule

// File: rtl/sfifo_top.sv
module sfifo_top
  import sfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DW     = 32,
  parameter int HALF_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pathEn,
  input  logic             waitSync,
  input  logic             flushOnSync,
  input  logic             syncAutoClr,
  input  logic             syncManClr,
  input  logic             wide32,
  input  logic             readySel,
  input  logic             irqEn,
  input  logic [CNT_W-1:0] thresh,
  input  logic             sampleValid,
  input  logic [DW-1:0]    sampleIn,
  input  logic             syncPulse,
  input  logic             fifoRd,
  input  logic             dataRd,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] fill,
  output logic [DW-1:0]    fifoData,
  output logic [DW-1:0]    dataReg,
  output logic             fifoReady,
  output logic             dataReady,
  output logic             syncFound,
  output logic             ovfErr,
  output logic             irq
);
  fifoStrobes_t str;

  sfifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .pathEn(pathEn), .waitSync(waitSync),
    .flushOnSync(flushOnSync), .syncAutoClr(syncAutoClr), .syncManClr(syncManClr),
    .readySel(readySel), .irqEn(irqEn), .thresh(thresh), .sampleValid(sampleValid),
    .syncPulse(syncPulse), .fifoRd(fifoRd), .dataRd(dataRd), .ovfClr(ovfClr),
    .fill(fill), .str(str), .fifoReady(fifoReady), .dataReady(dataReady),
    .syncFound(syncFound), .ovfErr(ovfErr), .irq(irq)
  );

  sfifo_datapath #(.DEPTH(DEPTH), .DW(DW), .HALF_W(HALF_W)) uPath (
    .clk(clk), .rstN(rstN), .str(str), .wide32(wide32), .sampleIn(sampleIn),
    .fill(fill), .fifoData(fifoData), .dataReg(dataReg)
  );

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRd && fill == '0) |=> $stable(fifoData));
endmodule

// File: tb/tb_sfifo_top.sv
`timescale 1ns/1ps
module tb_sfifo_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic pathEn = 0, waitSync = 0, flushOnSync = 0, syncAutoClr = 0, syncManClr = 0;
  logic wide32 = 1, readySel = 0, irqEn = 0;
  logic [4:0] thresh = '0;
  logic sampleValid = 0, syncPulse = 0, fifoRd = 0, dataRd = 0, ovfClr = 0;
  logic [31:0] sampleIn = '0;
  logic [4:0] fill;
  logic [31:0] fifoData, dataReg;
  logic fifoReady, dataReady, syncFound, ovfErr, irq;

  int checks = 0, errs = 0;
  bit done = 0;
  logic [31:0] expQ[$];
  logic [31:0] lastVal = '0;
  logic lastPop = 0;

  always #2 clk = ~clk;

  sfifo_top dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fmt(logic [31:0] d, logic w);
    return w ? d : {{16{d[15]}}, d[15:0]};
  endfunction

  // Driver: one sample strobe; record it when the bench expects storage.
  task automatic push(logic [31:0] d, bit expStore);
    @(negedge clk);
    sampleValid = 1; sampleIn = d;
    if (expStore && expQ.size() < 16) expQ.push_back(fmt(d, wide32));
    @(negedge clk);
    sampleValid = 0;
  endtask

  task automatic pop();
    @(negedge clk); fifoRd = 1;
    @(negedge clk); fifoRd = 0;
  endtask

  task automatic pulseSync();
    @(negedge clk); syncPulse = 1;
    @(negedge clk); syncPulse = 0;
  endtask

  // Monitor: compare each popped word with the scoreboard (R4, R5).
  always @(posedge clk) lastPop <= fifoRd;
  always @(negedge clk) begin
    if (lastPop) begin
      if (expQ.size() > 0) begin
        lastVal = expQ.pop_front();
        chk("R4 pop order", fifoData, lastVal);
      end else begin
        chk("R5 empty pop data", fifoData, lastVal);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1; errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 fill", 32'(fill), 0);
    chk("R1 flags", {28'd0, syncFound, ovfErr, dataReady, irq}, 0);
    chk("R1 data", fifoData | dataReg, 0);
    rstN = 1;
    // R2 disabled path ignores samples
    push(32'h11, 0);
    chk("R2 pathEn low", 32'(fill), 0);
    // R2 ungated storage
    pathEn = 1;
    push(32'hA0000001, 1); push(32'hA0000002, 1); push(32'hA0000003, 1);
    chk("R2 stored", 32'(fill), 3);
    thresh = 2; #1 chk("R6 fill>thresh", 32'(fifoReady), 1);
    thresh = 3; #1 chk("R6 fill==thresh", 32'(fifoReady), 0);
    thresh = 2; readySel = 1; irqEn = 0; #1 chk("R8 irq masked", 32'(irq), 0);
    irqEn = 1; #1 chk("R8 irq on", 32'(irq), 1);
    chk("R7 sel fifo", 32'(dataReady), 1);
    irqEn = 0;
    pop(); pop(); pop();
    pop();
    chk("R5 empty fill", 32'(fill), 0);
    // R11 width formats, R7 data register ready
    readySel = 0; wide32 = 0;
    push(32'h12348001, 1);
    chk("R11 sign ext reg", dataReg, 32'hFFFF8001);
    push(32'hAAAA1234, 1);
    chk("R11 narrow reg", dataReg, 32'h00001234);
    chk("R7 reg ready", 32'(dataReady), 1);
    @(negedge clk); dataRd = 1; @(negedge clk); dataRd = 0;
    chk("R7 read clears", 32'(dataReady), 0);
    pop(); pop();
    // R3 overflow
    wide32 = 1;
    for (int i = 0; i < 17; i++) push(32'hB000_0000 + i, 1);
    chk("R3 full fill", 32'(fill), 16);
    chk("R3 ovf flag", 32'(ovfErr), 1);
    thresh = 16; #1 chk("R6 thresh max", 32'(fifoReady), 0);
    thresh = 15; #1 chk("R6 thresh 15", 32'(fifoReady), 1);
    for (int i = 0; i < 16; i++) pop();
    @(negedge clk); ovfClr = 1; @(negedge clk); ovfClr = 0;
    chk("R3 ovf cleared", 32'(ovfErr), 0);
    // R2 sync gating, R10 manual clear, R9 flush
    @(negedge clk); pathEn = 0; @(negedge clk); pathEn = 1; waitSync = 1;
    push(32'hC1, 0);
    chk("R2 wait for sync", 32'(fill), 0);
    pulseSync();
    chk("R10 sync seen", 32'(syncFound), 1);
    push(32'hC2, 1); push(32'hC3, 1);
    chk("R2 armed stores", 32'(fill), 2);
    @(negedge clk); syncManClr = 1; @(negedge clk); syncManClr = 0;
    chk("R10 manual clear", 32'(syncFound), 0);
    pulseSync();
    chk("R9 no flush when off", 32'(fill), 2);
    flushOnSync = 1;
    pulseSync();
    expQ.delete();
    chk("R9 flushed", 32'(fill), 0);
    push(32'hC4, 1); pop();
    // R9 flushOnSync ignored without waitSync
    waitSync = 0;
    push(32'hC5, 1);
    pulseSync();
    chk("R9 ignored", 32'(fill), 1);
    pop();
    // R10 auto clear on buffer interrupt
    flushOnSync = 0; waitSync = 1; syncAutoClr = 1; irqEn = 1; thresh = 1;
    pulseSync();
    chk("R10 set before ready", 32'(syncFound), 1);
    push(32'hD1, 1); push(32'hD2, 1);
    @(negedge clk);
    chk("R10 auto clear", 32'(syncFound), 0);
    pop(); pop();
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule